// File: doc/BRIEF.md
# Single-Channel DMA Read Engine with Register File

This block is one DMA channel that a processor sets up through a small register file. Software loads a memory address, a quadword count and an optional tag address, then sets a start bit in the control register. The channel fetches the requested number of 128-bit quadwords from RAM over a read port that allows one outstanding request. It reports each step on a trace event output. Fetched data is only reported on that output and is not sent anywhere else.

When the transfer ends, the channel clears the start bit itself and increments a read-only completion counter. It also pulses an interrupt line. Software can therefore either poll the start bit or compare the counter against an earlier value, instead of waiting a fixed number of cycles.

Top module: `dma_chan`

## Requirements
- R1: Registers are selected by address bits [7:4] and are accessed only when address bits [3:0] are zero. Select 0 is control, 1 is memory address, 2 is quadword count (16 bits) and 3 is tag address. All four are writable and readable. A read accepted in one cycle shows its data on `reg_rd_data` with `reg_rd_valid` high in the next cycle. An unmapped or misaligned read returns zero, and every register is zero after reset.
- R2: Select 4 (offset 0x40) is a completion counter. It is zero after reset, rises by exactly one per finished transfer and ignores writes.
- R3: Writing control bit 8 as one starts a transfer. The channel clears bit 8 in the cycle after the done event. While bit 8 is set, a control write updates every other bit but leaves bit 8 set.
- R4: Memory requests are single-cycle pulses on `mem_req`, with `mem_addr` equal to the current memory address register. There is at most one outstanding request. The next request is issued in the cycle after the response, and no request is made while the channel is idle.
- R5: `ev_kind` encodes 1 = start, 2 = beat, 3 = done, and each is qualified by `ev_valid` with `ev_addr` set to the memory address register. The start event comes in the cycle after bit 8 is set. A beat event comes in the cycle of each response, carrying the response on `ev_data`. The done event comes in the cycle after the last beat.
- R6: `irq` is a one-cycle pulse in the same cycle as each done event.
- R7: Each beat adds 16 to the memory address register and subtracts 1 from the quadword count.
- R8: A transfer started with a count of zero gives a start event followed in the next cycle by a done event, with no memory request and no beat.
- R9: While bit 8 is set, writes to the memory address and count registers are ignored. Writes to the tag address register are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| reg_rd_data | output | 32 | Read data |
| mem_req | output | 1 | RAM read request pulse |
| mem_addr | output | 32 | RAM read byte address |
| mem_rsp_valid | input | 1 | RAM response valid |
| mem_rsp_data | input | 128 | RAM response quadword |
| ev_valid | output | 1 | Trace event valid |
| ev_kind | output | 2 | Event kind: 1 start, 2 beat, 3 done |
| ev_addr | output | 32 | Memory address register at the event |
| ev_data | output | 128 | Quadword carried by a beat event, zero otherwise |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A register write becomes visible one edge after its strobe, and a read returns data in the cycle after its strobe. The start event follows one cycle after bit 8 is written, and the first request follows one cycle after that. A beat is reported in the cycle its response arrives, and done with the interrupt appears one cycle after the last beat. Bit 8 then reads as zero from the next cycle. The bench keeps a behavioural model that advances once per clock and compares every output at the falling edge, so each result is checked in exactly the cycle it is due. Directed reads issued through the register port then confirm final addresses, counts and counter values against constants worked out by hand, and RAM latencies of 1, 2 and 3 cycles move the beats to different cycles.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_BEAT  = 2'd2,
        EV_DONE  = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_FIN  = 2'd3
    } xfer_st_e;

    // register selects, taken from address bits [7:4]
    localparam logic [3:0] SEL_CTRL = 4'd0;
    localparam logic [3:0] SEL_MADR = 4'd1;
    localparam logic [3:0] SEL_QWC  = 4'd2;
    localparam logic [3:0] SEL_TADR = 4'd3;
    localparam logic [3:0] SEL_CNT  = 4'd4;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 32,
    parameter int QW        = 16,
    parameter int CW        = 32,
    parameter int START_BIT = 8,
    parameter int STRIDE    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [7:0]    rd_addr,
    input  logic          step,
    input  logic          finish,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic [AW-1:0] madr,
    output logic [QW-1:0] qwc
);

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [AW-1:0] madr;
        logic [QW-1:0] qwc;
        logic [DW-1:0] tadr;
        logic [CW-1:0] cnt;
        logic          rd_valid;
        logic [DW-1:0] rd_data;
    } regs_t;

    regs_t q, d;

    logic wr_hit;
    logic rd_hit;

    assign wr_hit = wr_en && (wr_addr[3:0] == 4'd0);
    assign rd_hit = rd_en && (rd_addr[3:0] == 4'd0);
    assign busy   = q.ctrl[START_BIT];

    always_comb begin
        d          = q;
        d.rd_valid = rd_en;
        d.rd_data  = '0;

        if (rd_hit) begin
            case (rd_addr[7:4])
                SEL_CTRL: d.rd_data = q.ctrl;
                SEL_MADR: d.rd_data = DW'(q.madr);
                SEL_QWC:  d.rd_data = DW'(q.qwc);
                SEL_TADR: d.rd_data = q.tadr;
                SEL_CNT:  d.rd_data = DW'(q.cnt);
                default:  d.rd_data = '0;
            endcase
        end

        if (wr_hit) begin
            case (wr_addr[7:4])
                SEL_CTRL: begin
                    d.ctrl = wr_data;
                    if (busy) d.ctrl[START_BIT] = 1'b1;
                end
                SEL_MADR: if (!busy) d.madr = AW'(wr_data);
                SEL_QWC:  if (!busy) d.qwc  = QW'(wr_data);
                SEL_TADR: d.tadr = wr_data;
                default: ;
            endcase
        end

        if (step) begin
            d.madr = q.madr + AW'(STRIDE);
            d.qwc  = q.qwc - QW'(1);
        end

        if (finish) begin
            d.ctrl[START_BIT] = 1'b0;
            d.cnt             = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
    assign madr     = q.madr;
    assign qwc      = q.qwc;

endmodule

// File: rtl/dma_chan_xfer.sv
module dma_chan_xfer
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int QW = 16,
    parameter int BW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic [AW-1:0] madr,
    input  logic [QW-1:0] qwc,
    input  logic          mem_rsp_valid,
    input  logic [BW-1:0] mem_rsp_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          step,
    output logic          finish,
    output logic          ev_valid,
    output logic [1:0]    ev_kind,
    output logic [AW-1:0] ev_addr,
    output logic [BW-1:0] ev_data
);

    typedef struct packed {
        xfer_st_e st;
    } xfer_t;

    xfer_t    q, d;
    ev_kind_e kind;

    always_comb begin
        d       = q;
        mem_req = 1'b0;
        step    = 1'b0;
        finish  = 1'b0;
        kind    = EV_NONE;
        ev_data = '0;

        case (q.st)
            ST_IDLE: begin
                if (busy) begin
                    kind = EV_START;
                    d.st = (qwc == '0) ? ST_FIN : ST_REQ;
                end
            end
            ST_REQ: begin
                mem_req = 1'b1;
                d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    kind    = EV_BEAT;
                    ev_data = mem_rsp_data;
                    step    = 1'b1;
                    d.st    = (qwc == QW'(1)) ? ST_FIN : ST_REQ;
                end
            end
            ST_FIN: begin
                kind   = EV_DONE;
                finish = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE};
        else        q <= d;
    end

    assign ev_valid = (kind != EV_NONE);
    assign ev_kind  = kind;
    assign ev_addr  = ev_valid ? madr : '0;
    assign mem_addr = mem_req ? madr : '0;

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 32,
    parameter int QW        = 16,
    parameter int CW        = 32,
    parameter int BW        = 128,
    parameter int START_BIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [7:0]    reg_wr_addr,
    input  logic [DW-1:0] reg_wr_data,
    input  logic          reg_rd_en,
    input  logic [7:0]    reg_rd_addr,
    output logic          reg_rd_valid,
    output logic [DW-1:0] reg_rd_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rsp_valid,
    input  logic [BW-1:0] mem_rsp_data,
    output logic          ev_valid,
    output logic [1:0]    ev_kind,
    output logic [AW-1:0] ev_addr,
    output logic [BW-1:0] ev_data,
    output logic          irq
);

    localparam int STRIDE = BW / 8;

    logic          busy_w;
    logic          step_w;
    logic          finish_w;
    logic [AW-1:0] madr_w;
    logic [QW-1:0] qwc_w;

    dma_chan_regs #(
        .DW(DW), .AW(AW), .QW(QW), .CW(CW),
        .START_BIT(START_BIT), .STRIDE(STRIDE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .rd_en    (reg_rd_en),
        .rd_addr  (reg_rd_addr),
        .step     (step_w),
        .finish   (finish_w),
        .rd_valid (reg_rd_valid),
        .rd_data  (reg_rd_data),
        .busy     (busy_w),
        .madr     (madr_w),
        .qwc      (qwc_w)
    );

    dma_chan_xfer #(
        .AW(AW), .QW(QW), .BW(BW)
    ) u_xfer (
        .clk           (clk),
        .rst_n         (rst_n),
        .busy          (busy_w),
        .madr          (madr_w),
        .qwc           (qwc_w),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .step          (step_w),
        .finish        (finish_w),
        .ev_valid      (ev_valid),
        .ev_kind       (ev_kind),
        .ev_addr       (ev_addr),
        .ev_data       (ev_data)
    );

    // the interrupt pulse is the cycle in which the channel retires a transfer
    assign irq = finish_w;

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_req,
    input logic       mem_rsp_valid,
    input logic       ev_valid,
    input logic [1:0] ev_kind,
    input logic       irq,
    input logic       busy
);

    // R6: interrupt only together with a done event
    a_r6_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ev_valid && ev_kind == 2'd3));

    // R3: start bit is gone the cycle after completion
    a_r3_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !busy);

    // R4: a request never lasts two cycles (one outstanding)
    a_r4_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R4: no request while idle
    a_r4_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R5: a beat needs a response in the same cycle
    a_r5_beat_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 2'd2) |-> mem_rsp_valid);

    // R5: start event only with the start bit set
    a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 2'd1) |-> busy);

endmodule

bind dma_chan dma_chan_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_rsp_valid (mem_rsp_valid),
    .ev_valid      (ev_valid),
    .ev_kind       (ev_kind),
    .irq           (irq),
    .busy          (busy_w)
);

// File: tb/dma_chan_bench.sv
`timescale 1ns/1ps
module dma_chan_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [7:0]   reg_wr_addr = '0;
    logic [31:0]  reg_wr_data = '0;
    logic         reg_rd_en = 1'b0;
    logic [7:0]   reg_rd_addr = '0;
    logic         reg_rd_valid;
    logic [31:0]  reg_rd_data;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;
    logic         ev_valid;
    logic [1:0]   ev_kind;
    logic [31:0]  ev_addr;
    logic [127:0] ev_data;
    logic         irq;

    always #4 clk = ~clk;

    dma_chan u_dma_chan (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
        .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_data(ev_data),
        .irq(irq)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int n_beat  = 0;
    int n_irq   = 0;
    int n_req   = 0;
    int lat     = 1;
    int cd      = 0;
    logic [31:0] cap = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_ctrl = '0, m_madr = '0, m_tadr = '0, m_cnt = '0, m_rdd = '0;
    logic [15:0] m_qwc = '0;
    logic        m_rdv = 1'b0;
    int          m_st  = 0;

    function automatic logic [31:0] mread(input logic [7:0] a);
        if (a[3:0] != 4'd0) return 32'd0;
        case (a[7:4])
            4'd0: return m_ctrl;
            4'd1: return m_madr;
            4'd2: return {16'd0, m_qwc};
            4'd3: return m_tadr;
            4'd4: return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        logic         e_req, e_ev, stp, fin, bsy;
        logic [1:0]   e_kind;
        logic [31:0]  e_maddr, e_addr;
        logic [127:0] e_data;
        int           nst;
        if (rst_n) begin
            e_req   = (m_st == 1);
            e_maddr = e_req ? m_madr : 32'd0;
            e_ev = 0; e_kind = 0; e_data = '0; stp = 0; fin = 0; nst = m_st;
            case (m_st)
                0: if (m_ctrl[8]) begin e_ev = 1; e_kind = 1; nst = (m_qwc == 0) ? 3 : 1; end
                1: nst = 2;
                2: if (mem_rsp_valid) begin
                       e_ev = 1; e_kind = 2; e_data = {4{m_madr ^ 32'h5A5A_0000}};
                       stp = 1; nst = (m_qwc == 1) ? 3 : 1;
                   end
                default: begin e_ev = 1; e_kind = 3; fin = 1; nst = 0; end
            endcase
            e_addr = e_ev ? m_madr : 32'd0;

            chk(mem_req === e_req && mem_addr === e_maddr, "R4", "mem request",
                {mem_req, mem_addr}, {e_req, e_maddr});
            chk(ev_valid === e_ev && ev_kind === e_kind && ev_addr === e_addr, "R5", "event",
                {ev_valid, ev_kind, ev_addr}, {e_ev, e_kind, e_addr});
            chk(ev_data === e_data, "R5", "beat data", ev_data, e_data);
            chk(irq === fin, "R6", "irq", irq, fin);
            chk(reg_rd_valid === m_rdv && reg_rd_data === m_rdd, "R1", "read port",
                {reg_rd_valid, reg_rd_data}, {m_rdv, m_rdd});

            if (ev_valid && ev_kind == 2'd2) n_beat++;
            if (irq) n_irq++;
            if (mem_req) begin n_req++; cd = lat; cap = mem_addr; end

            // model next state
            m_rdv = reg_rd_en;
            m_rdd = reg_rd_en ? mread(reg_rd_addr) : 32'd0;
            bsy = m_ctrl[8];
            if (reg_wr_en && reg_wr_addr[3:0] == 4'd0) begin
                case (reg_wr_addr[7:4])
                    4'd0: m_ctrl = bsy ? (reg_wr_data | 32'h100) : reg_wr_data;
                    4'd1: if (!bsy) m_madr = reg_wr_data;
                    4'd2: if (!bsy) m_qwc = reg_wr_data[15:0];
                    4'd3: m_tadr = reg_wr_data;
                    default: ;
                endcase
            end
            if (stp) begin m_madr = m_madr + 32'd16; m_qwc = m_qwc - 16'd1; end
            if (fin) begin m_ctrl[8] = 1'b0; m_cnt = m_cnt + 32'd1; end
            m_st = nst;
        end
    end

    // RAM responder: answers after lat cycles
    always @(posedge clk) begin
        #1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = {4{cap ^ 32'h5A5A_0000}};
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = v;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        reg_rd_en = 1'b1; reg_rd_addr = a;
        @(posedge clk); #1;
        reg_rd_en = 1'b0;
        @(negedge clk);
        v = reg_rd_data;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(v === exp, tag, $sformatf("read 0x%02h", a), v, exp);
    endtask

    task automatic wait_clear();
        logic [31:0] v = 32'h100;
        for (int i = 0; i < 200; i++) begin
            rd(8'h00, v);
            if (!v[8]) break;
        end
        chk(!v[8], "R3", "start bit polled clear", v, v & ~32'h100);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R3 watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R2: reset values, misaligned read
        rd_chk(8'h00, 32'h0, "R1");
        rd_chk(8'h10, 32'h0, "R1");
        rd_chk(8'h20, 32'h0, "R1");
        rd_chk(8'h30, 32'h0, "R1");
        rd_chk(8'h40, 32'h0, "R2");

        // transfer 1: three beats, latency 1
        lat = 1;
        wr(8'h10, 32'h0000_1000);
        wr(8'h20, 32'h0000_0003);
        wr(8'h30, 32'hCAFE_0000);
        wr(8'h18, 32'h0000_7777);           // misaligned: no effect (R1)
        rd_chk(8'h10, 32'h0000_1000, "R1");
        rd_chk(8'h30, 32'hCAFE_0000, "R1");
        rd_chk(8'h08, 32'h0, "R1");
        wr(8'h00, 32'h0000_0105);
        wr(8'h10, 32'h000D_EAD0);           // R9: ignored while busy
        wr(8'h20, 32'h0000_0007);           // R9: ignored while busy
        wr(8'h30, 32'h0000_1234);           // R9: tag still accepted
        wait_clear();
        rd_chk(8'h10, 32'h0000_1030, "R7");
        rd_chk(8'h20, 32'h0, "R7");
        rd_chk(8'h30, 32'h0000_1234, "R9");
        rd_chk(8'h40, 32'd1, "R2");
        rd_chk(8'h00, 32'h0000_0005, "R3");

        // transfer 2: two beats, latency 3, control rewrite mid-transfer
        lat = 3;
        wr(8'h10, 32'h0000_2000);
        wr(8'h20, 32'h0000_0002);
        wr(8'h00, 32'h0000_0100);
        wr(8'h00, 32'h0000_00AB);           // R3: bit 8 held, others updated
        rd_chk(8'h00, 32'h0000_01AB, "R3");
        wait_clear();
        rd_chk(8'h00, 32'h0000_00AB, "R3");
        rd_chk(8'h10, 32'h0000_2020, "R7");
        rd_chk(8'h40, 32'd2, "R2");

        // transfer 3: zero count
        wr(8'h10, 32'h0000_3000);
        wr(8'h00, 32'h0000_0100);
        wait_clear();
        rd_chk(8'h10, 32'h0000_3000, "R8");
        rd_chk(8'h40, 32'd3, "R8");

        // R2: counter ignores writes
        wr(8'h40, 32'h0000_0099);
        rd_chk(8'h40, 32'd3, "R2");

        // transfer 4: one beat, latency 2
        lat = 2;
        wr(8'h10, 32'hFFFF_FFF0);
        wr(8'h20, 32'h0000_0001);
        wr(8'h00, 32'h0000_0100);
        wait_clear();
        rd_chk(8'h10, 32'h0000_0000, "R7");
        rd_chk(8'h40, 32'd4, "R2");

        repeat (4) @(posedge clk);
        chk(n_beat == 6, "R5", "total beats", n_beat, 6);
        chk(n_req == 6, "R4", "total requests", n_req, 6);
        chk(n_irq == 4, "R6", "total interrupts", n_irq, 4);
        summary();
        $finish;
    end

endmodule